// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block is the control-plane front end of an eight-channel, two-group signal conditioner. An I2C master reads and writes a bank of twelve 8-bit configuration bytes through it. The block oversamples SCL and SDA with the system clock and recognises START and STOP conditions. It compares the address byte against a 7-bit device address, and three of those address bits come from board pins. It acknowledges every byte it accepts by pulling SDA low through an output-enable. The block never stretches the clock.

The block has no register pointer, so every transfer starts at byte 0. A write discards its first data byte and stores the following bytes at 0, 1, 2 and upward. A read returns byte 0 first and counts upward until the master answers with a NACK. Bytes 0 and 1 mirror the live signal-detect and receiver-detect inputs. The other bytes are loaded once from strap pins in the first clock after reset. After that they change only through I2C, and only while the lock input is low.

Top module: `cfgbank_i2c_slave`

## Requirements
- R1: The device answers only to the address {1,1,A4,0,0,A1,A0}, where addr_sel_i = {A4,A1,A0}. The bit that follows the address is 1 for a read and 0 for a write. An address that does not match gets no ACK.
- R2: In a write, the first byte after the address is ACKed and then discarded. Each later byte k is stored at byte index k, starting from 0. Writes aimed at bytes 0 and 1 are ACKed and have no effect.
- R3: A read returns byte 0 first and then the following bytes in ascending order, each sent MSB first. The read ends when the master NACKs. Any byte read beyond index 11 returns 0xFF.
- R4: Each ACK holds SDA low for the whole high phase of the ninth SCL pulse. The block changes SDA only while SCL is low.
- R5: While cfg_lock_i is high, an I2C write changes no stored byte. The lock acts on its current level and is not latched.
- R6: In the first clock after reset the strap pins load the bank, and this happens once. Byte 2 takes the loop-control strap on bits 7:4, the group A emphasis strap on bit 3 and the group B emphasis strap on bit 2. The channel-reset strap fills byte 5 and the power strap fills byte 6. In byte 7, bits 7,5,3,1 take the group A receiver-detect strap and bits 6,4,2,0 take the group B one. Bytes 8 and 9 take strap_grp_a_i and strap_grp_b_i as given.
- R7: Byte 0 reads sig_det_i and byte 1 reads rx_det_i, both live. Bits 1:0 of byte 2 always read 0 and cannot be written.
- R8: Bytes 3, 4, 10 and 11 hold 0x00 after reset, and all four are writable.
- R9: A write data byte aimed past index 11 is NACKed and discarded.
- R10: A repeated START in the middle of a transfer starts the byte count again at 0.
- R11: A STOP releases SDA and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_sel_i | input | 3 | Pin-selected address bits {A4,A1,A0} |
| cfg_lock_i | input | 1 | 1 blocks I2C writes |
| strap_loop_n_i | input | 1 | Loop-control strap (byte 2 bits 7:4) |
| strap_emph_a_i | input | 1 | Group A emphasis strap (byte 2 bit 3) |
| strap_emph_b_i | input | 1 | Group B emphasis strap (byte 2 bit 2) |
| strap_chrst_n_i | input | 1 | Channel-reset strap (byte 5) |
| strap_pwr_n_i | input | 1 | Power strap (byte 6) |
| strap_rxdet_a_i | input | 1 | Group A receiver-detect enable strap (byte 7) |
| strap_rxdet_b_i | input | 1 | Group B receiver-detect enable strap (byte 7) |
| strap_grp_a_i | input | 8 | Group A equaliser/emphasis/swing straps (byte 8) |
| strap_grp_b_i | input | 8 | Group B equaliser/emphasis/swing straps (byte 9) |
| sig_det_i | input | 8 | Live signal-detect status (byte 0) |
| rx_det_i | input | 8 | Live receiver-detect result (byte 1) |
| cfg_o | output | 96 | Bank image, byte n at bits 8n+7:8n |

## Verification
The bench builds the block with its default parameters. These are two synchroniser stages and the fixed address bits 11 and 00. The address pins are tied to 101, which gives device address 0x71, and 0x61 serves as the near-miss address that differs only in the A4 position. SCL runs at 1/24 of the system clock, just above the 20x floor. At that rate the three-cycle sampling delay takes up a real share of each low phase, which exercises ACK release and data hand-over under tight timing. With twelve bytes, the bench can push bursts one past the last index and can place a repeated START after two data bytes.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int CFG_BYTES    = 12;
  localparam int IDX_W        = $clog2(CFG_BYTES + 1);
  localparam int STATUS_BYTES = 2;
  localparam int LOOP_BYTE    = 2;
  localparam int CHRST_BYTE   = 5;
  localparam int PWR_BYTE     = 6;
  localparam int RXDET_BYTE   = 7;
  localparam int GRPA_BYTE    = 8;
  localparam int GRPB_BYTE    = 9;
  localparam logic [7:0] LOOP_WMASK = 8'hFC;
  localparam logic [7:0] PAST_END   = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_TX_NEXT
  } fsm_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_DUMMY, PH_WDATA
  } phase_e;
endpackage

// File: rtl/cfgbank_line_sync.sv
module cfgbank_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], line_i};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/cfgbank_i2c_engine.sv
module cfgbank_i2c_engine
  import cfgbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic             scl_prev,
  input  logic             sda_lvl,
  input  logic             sda_prev,
  input  logic [6:0]       dev_addr,
  input  logic [7:0]       rd_data,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [7:0]       wr_data_o,
  output logic             idle_o
);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(CFG_BYTES);

  fsm_e             state_q, state_d;
  phase_e           phase_q, phase_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [7:0]       sh_q, sh_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             rw_q, rw_d;
  logic             oe_q, oe_d;
  logic             wr_en;

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

  function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] v);
    return (v == IDX_END) ? v : v + IDX_W'(1);
  endfunction

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    rw_d    = rw_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;
    if (start_det) begin
      state_d = ST_RX;
      phase_d = PH_ADDR;
      cnt_d   = 4'd0;
      idx_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_d = 4'd0;
            case (phase_q)
              PH_ADDR: begin
                if (sh_q[7:1] == dev_addr) begin
                  oe_d    = 1'b1;
                  rw_d    = sh_q[0];
                  state_d = ST_RX_ACK;
                end else begin
                  state_d = ST_IDLE;
                end
              end
              PH_DUMMY: begin
                oe_d    = 1'b1;
                state_d = ST_RX_ACK;
              end
              default: begin
                state_d = ST_RX_ACK;
                if (idx_q < IDX_END) begin
                  oe_d  = 1'b1;
                  wr_en = 1'b1;
                  idx_d = idx_step(idx_q);
                end
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            oe_d = 1'b0;
            if (phase_q == PH_ADDR && rw_q) begin
              state_d = ST_TX;
              sh_d    = rd_data;
              oe_d    = ~rd_data[7];
              idx_d   = idx_step(idx_q);
            end else begin
              state_d = ST_RX;
              phase_d = (phase_q == PH_ADDR) ? PH_DUMMY : PH_WDATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_d    = 1'b0;
              cnt_d   = 4'd0;
              state_d = ST_TX_ACK;
            end else begin
              sh_d = {sh_q[6:0], 1'b1};
              oe_d = ~sh_q[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) state_d = sda_lvl ? ST_IDLE : ST_TX_NEXT;
        end
        ST_TX_NEXT: begin
          if (scl_fall) begin
            state_d = ST_TX;
            sh_d    = rd_data;
            oe_d    = ~rd_data[7];
            idx_d   = idx_step(idx_q);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_ADDR;
      cnt_q   <= 4'd0;
      sh_q    <= 8'h00;
      idx_q   <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      rw_q    <= rw_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_en;
  assign idx_o     = idx_q;
  assign wr_data_o = sh_q;
  assign idle_o    = (state_q == ST_IDLE);
endmodule

// File: rtl/cfgbank_regs.sv
module cfgbank_regs
  import cfgbank_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       idx,
  input  logic [7:0]             wr_data,
  input  logic                   wr_lock,
  input  logic                   strap_loop_n,
  input  logic                   strap_emph_a,
  input  logic                   strap_emph_b,
  input  logic                   strap_chrst_n,
  input  logic                   strap_pwr_n,
  input  logic                   strap_rxdet_a,
  input  logic                   strap_rxdet_b,
  input  logic [7:0]             strap_grp_a,
  input  logic [7:0]             strap_grp_b,
  input  logic [7:0]             sig_det,
  input  logic [7:0]             rx_det,
  output logic [7:0]             rd_data,
  output logic [CFG_BYTES*8-1:0] image_o,
  output logic                   cap_done_o
);
  logic       cap_q, cap_d;
  logic [7:0] strap_byte [CFG_BYTES];
  logic [7:0] bank       [CFG_BYTES];

  assign cap_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= 1'b0;
    else        cap_q <= cap_d;
  end

  always_comb begin
    for (int i = 0; i < CFG_BYTES; i++) strap_byte[i] = 8'h00;
    strap_byte[LOOP_BYTE]  = {{4{strap_loop_n}}, strap_emph_a, strap_emph_b, 2'b00};
    strap_byte[CHRST_BYTE] = {8{strap_chrst_n}};
    strap_byte[PWR_BYTE]   = {8{strap_pwr_n}};
    strap_byte[RXDET_BYTE] = {4{strap_rxdet_a, strap_rxdet_b}};
    strap_byte[GRPA_BYTE]  = strap_grp_a;
    strap_byte[GRPB_BYTE]  = strap_grp_b;
  end

  for (genvar g = 0; g < CFG_BYTES; g++) begin : g_byte
    if (g == 0) begin : g_sig
      assign bank[g] = sig_det;
    end else if (g == 1) begin : g_rx
      assign bank[g] = rx_det;
    end else begin : g_store
      localparam logic [7:0] WMASK = (g == LOOP_BYTE) ? LOOP_WMASK : 8'hFF;
      logic [7:0] q, d;
      logic       hit, en;
      assign hit = wr_en && !wr_lock && (idx == IDX_W'(g));
      assign en  = !cap_q || hit;
      always_comb begin
        if (!cap_q) d = strap_byte[g];
        else        d = (q & ~WMASK) | (wr_data & WMASK);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 8'h00;
        else if (en) q <= d;
      end
      assign bank[g] = q;
    end
    assign image_o[g*8 +: 8] = bank[g];
  end

  assign rd_data    = (idx < IDX_W'(CFG_BYTES)) ? bank[idx] : PAST_END;
  assign cap_done_o = cap_q;
endmodule

// File: rtl/cfgbank_i2c_slave.sv
module cfgbank_i2c_slave
  import cfgbank_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [1:0] DEV_ID_HI   = 2'b11,
  parameter logic [1:0] DEV_ID_MID  = 2'b00
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  input  logic [2:0]             addr_sel_i,
  input  logic                   cfg_lock_i,
  input  logic                   strap_loop_n_i,
  input  logic                   strap_emph_a_i,
  input  logic                   strap_emph_b_i,
  input  logic                   strap_chrst_n_i,
  input  logic                   strap_pwr_n_i,
  input  logic                   strap_rxdet_a_i,
  input  logic                   strap_rxdet_b_i,
  input  logic [7:0]             strap_grp_a_i,
  input  logic [7:0]             strap_grp_b_i,
  input  logic [7:0]             sig_det_i,
  input  logic [7:0]             rx_det_i,
  output logic [CFG_BYTES*8-1:0] cfg_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, lvl, prev;
  logic             scl_lvl, scl_prev, sda_lvl, sda_prev;
  logic [6:0]       dev_addr;
  logic [7:0]       rd_data, wr_data;
  logic [IDX_W-1:0] idx;
  logic             wr_en, cap_done, eng_idle;

  assign raw = {sda_i, scl_i};

  for (genvar gl = 0; gl < LINES; gl++) begin : g_line
    cfgbank_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw[gl]),
      .lvl_o  (lvl[gl]),
      .prev_o (prev[gl])
    );
  end

  assign scl_lvl  = lvl[0];
  assign scl_prev = prev[0];
  assign sda_lvl  = lvl[1];
  assign sda_prev = prev[1];
  assign dev_addr = {DEV_ID_HI, addr_sel_i[2], DEV_ID_MID, addr_sel_i[1:0]};

  cfgbank_i2c_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .scl_prev  (scl_prev),
    .sda_lvl   (sda_lvl),
    .sda_prev  (sda_prev),
    .dev_addr  (dev_addr),
    .rd_data   (rd_data),
    .sda_oe_o  (sda_oe_o),
    .wr_en_o   (wr_en),
    .idx_o     (idx),
    .wr_data_o (wr_data),
    .idle_o    (eng_idle)
  );

  cfgbank_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .idx           (idx),
    .wr_data       (wr_data),
    .wr_lock       (cfg_lock_i),
    .strap_loop_n  (strap_loop_n_i),
    .strap_emph_a  (strap_emph_a_i),
    .strap_emph_b  (strap_emph_b_i),
    .strap_chrst_n (strap_chrst_n_i),
    .strap_pwr_n   (strap_pwr_n_i),
    .strap_rxdet_a (strap_rxdet_a_i),
    .strap_rxdet_b (strap_rxdet_b_i),
    .strap_grp_a   (strap_grp_a_i),
    .strap_grp_b   (strap_grp_b_i),
    .sig_det       (sig_det_i),
    .rx_det        (rx_det_i),
    .rd_data       (rd_data),
    .image_o       (cfg_o),
    .cap_done_o    (cap_done)
  );
endmodule

// File: rtl/cfgbank_i2c_slave_chk.sv
module cfgbank_i2c_slave_chk
  import cfgbank_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sda_oe,
  input logic [CFG_BYTES*8-1:0] cfg,
  input logic                   lock,
  input logic                   scl_lvl,
  input logic                   sda_lvl,
  input logic                   sda_prev,
  input logic                   cap_done,
  input logic                   idle
);
  // R5: a locked bank keeps every stored byte across the next edge
  a_r5_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && lock) |=> $stable(cfg[CFG_BYTES*8-1:STATUS_BYTES*8]));

  // R7: reserved bits of the loop byte stay clear once loaded
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> (cfg[LOOP_BYTE*8 +: 2] == 2'b00));

  // R4: SDA enable only moves while sampled SCL is low
  a_r4_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);

  // R11: a STOP on the bus leaves SDA released
  a_r11_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && !sda_prev && sda_lvl) |=> !sda_oe);

  // R11: the idle engine never pulls SDA
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);
endmodule

bind cfgbank_i2c_slave cfgbank_i2c_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe_o),
  .cfg      (cfg_o),
  .lock     (cfg_lock_i),
  .scl_lvl  (scl_lvl),
  .sda_lvl  (sda_lvl),
  .sda_prev (sda_prev),
  .cap_done (cap_done),
  .idle     (eng_idle)
);

// File: tb/cfgbank_i2c_slave_tb_top.sv
module cfgbank_i2c_slave_tb_top;
  localparam int NB = 12;
  localparam int Q  = 6;
  localparam int H  = 12;
  localparam logic [6:0] DEV   = 7'h71;
  localparam logic [6:0] WRONG = 7'h61;
  localparam int NV = 10;
  // {index, write data, lock, expected readback}
  localparam logic [20:0] VEC [NV] = '{
    {4'd3,  8'h3C, 1'b0, 8'h3C},
    {4'd4,  8'hA5, 1'b0, 8'hA5},
    {4'd2,  8'h57, 1'b0, 8'h54},
    {4'd10, 8'h81, 1'b0, 8'h81},
    {4'd11, 8'h7E, 1'b0, 8'h7E},
    {4'd8,  8'h11, 1'b1, 8'h5A},
    {4'd5,  8'h00, 1'b0, 8'h00},
    {4'd0,  8'h99, 1'b0, 8'h96},
    {4'd9,  8'h00, 1'b1, 8'hC3},
    {4'd6,  8'h0F, 1'b0, 8'h0F}
  };

  logic clk, rst_n, scl, sda_m, lock;
  logic [7:0] sig_det, rx_det;
  logic [95:0] cfg;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks, fails;
  logic done;
  logic [7:0] shadow [NB];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  logic [15:0] acks;
  logic s1, s2;

  cfgbank_i2c_slave dut_i (
    .clk (clk), .rst_n (rst_n), .scl_i (scl), .sda_i (sda_bus), .sda_oe_o (sda_oe),
    .addr_sel_i (3'b101), .cfg_lock_i (lock),
    .strap_loop_n_i (1'b1), .strap_emph_a_i (1'b1), .strap_emph_b_i (1'b0),
    .strap_chrst_n_i (1'b1), .strap_pwr_n_i (1'b1),
    .strap_rxdet_a_i (1'b1), .strap_rxdet_b_i (1'b0),
    .strap_grp_a_i (8'h5A), .strap_grp_b_i (8'hC3),
    .sig_det_i (sig_det), .rx_det_i (rx_det), .cfg_o (cfg)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl = 1'b0; wt(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    for (int b = 7; b >= 0; b--) begin
      sda_m = d[b]; wt(Q); scl = 1'b1; wt(H); scl = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(3); s1 = sda_bus; wt(H-6); s2 = sda_bus; wt(3);
    scl = 1'b0; wt(Q);
    ack = !s1 && !s2;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int b = 7; b >= 0; b--) begin
      wt(Q); scl = 1'b1; wt(H/2); d[b] = sda_bus; wt(H/2); scl = 1'b0; wt(Q);
    end
    sda_m = !mack; wt(Q); scl = 1'b1; wt(H); scl = 1'b0; sda_m = 1'b1; wt(Q);
  endtask

  task automatic do_write(input int n);
    logic a;
    acks = '0;
    i2c_start();
    wbyte({DEV, 1'b0}, a); acks[0] = a;
    wbyte(8'hE7, a); acks[1] = a;
    for (int i = 0; i < n; i++) begin
      wbyte(wbuf[i], a); acks[i+2] = a;
    end
    i2c_stop();
  endtask

  task automatic do_read(input int n);
    logic a;
    i2c_start();
    wbyte({DEV, 1'b1}, a); acks[0] = a;
    for (int i = 0; i < n; i++) rbyte(i != n-1, rbuf[i]);
    i2c_stop();
  endtask

  initial begin : watchdog
    wt(190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic a;
    logic [3:0] vi;
    logic [7:0] vd, ve;
    logic vl;
    logic all_ok;
    string tag;
    checks = 0; fails = 0; done = 1'b0;
    scl = 1'b1; sda_m = 1'b1; lock = 1'b0; sig_det = 8'h96; rx_det = 8'h3C;
    rst_n = 1'b0; wt(5); rst_n = 1'b1; wt(5);

    // reset state: strap capture R6, cleared bytes R8, status and reserved R7
    shadow[0] = 8'h96; shadow[1] = 8'h3C; shadow[2] = 8'hF8; shadow[3] = 8'h00;
    shadow[4] = 8'h00; shadow[5] = 8'hFF; shadow[6] = 8'hFF; shadow[7] = 8'hAA;
    shadow[8] = 8'h5A; shadow[9] = 8'hC3; shadow[10] = 8'h00; shadow[11] = 8'h00;
    for (int i = 0; i < NB; i++) begin
      tag = (i == 3 || i == 4 || i >= 10) ? "R8 reset byte" : (i < 2 ? "R7 status" : "R6 strap");
      check(cfg[i*8 +: 8] == shadow[i], tag, cfg[i*8 +: 8], shadow[i]);
    end
    check(sda_oe == 1'b0, "R11 released after reset", sda_oe, 0);

    // vector table walk (R2 R3 R5 R7)
    for (int v = 0; v < NV; v++) begin
      {vi, vd, vl, ve} = VEC[v];
      tag = vl ? "R5 locked write" : ((vi < 3) ? "R7 protected bits" : "R2 write");
      lock = vl;
      for (int i = 0; i < vi; i++) wbuf[i] = shadow[i];
      wbuf[vi] = vd;
      do_write(int'(vi) + 1);
      lock = 1'b0;
      all_ok = 1'b1;
      for (int i = 0; i < int'(vi) + 3; i++) if (!acks[i]) all_ok = 1'b0;
      check(all_ok, "R2 burst acked", acks, 16'hFFFF);
      do_read(NB);
      check(rbuf[vi] == ve, tag, rbuf[vi], ve);
      shadow[vi] = ve;
      all_ok = 1'b1;
      for (int i = 0; i < NB; i++) if (rbuf[i] != shadow[i]) all_ok = 1'b0;
      check(all_ok, "R3 ascending readback", 0, 0);
      all_ok = 1'b1;
      for (int i = 0; i < NB; i++) if (cfg[i*8 +: 8] != shadow[i]) all_ok = 1'b0;
      check(all_ok, "R2 image matches", 0, 0);
    end

    // R1: near-miss address gets no ACK, bank untouched
    i2c_start(); wbyte({WRONG, 1'b0}, a); i2c_stop();
    check(!a, "R1 wrong address nacked", a, 0);
    check(sda_oe == 1'b0, "R11 released after stop", sda_oe, 0);

    // R4: address ACK held low over the whole high phase
    i2c_start(); wbyte({DEV, 1'b1}, a);
    check(!s1 && !s2, "R4 ack held", {s1, s2}, 0);
    rbyte(1'b0, rbuf[0]); i2c_stop();
    check(rbuf[0] == shadow[0], "R3 first read byte is byte 0", rbuf[0], shadow[0]);

    // R9: write past the last byte
    for (int i = 0; i < NB; i++) wbuf[i] = shadow[i];
    wbuf[NB] = 8'h00;
    do_write(NB + 1);
    check(acks[NB+1] == 1'b1, "R9 last byte acked", acks[NB+1], 1);
    check(acks[NB+2] == 1'b0, "R9 overflow byte nacked", acks[NB+2], 0);
    all_ok = 1'b1;
    for (int i = 0; i < NB; i++) if (cfg[i*8 +: 8] != shadow[i]) all_ok = 1'b0;
    check(all_ok, "R9 bank unchanged", 0, 0);

    // R3: read past the last byte returns 0xFF
    do_read(NB + 1);
    check(rbuf[NB] == 8'hFF, "R3 past end", rbuf[NB], 8'hFF);
    check(rbuf[11] == shadow[11], "R3 last byte", rbuf[11], shadow[11]);

    // R10: repeated START restarts the count at 0
    i2c_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h00, a);
    wbyte(shadow[0], a); wbyte(shadow[1], a);
    i2c_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h00, a);
    wbyte(shadow[0], a); wbyte(shadow[1], a); wbyte(shadow[2], a); wbyte(8'h42, a);
    i2c_stop();
    check(cfg[3*8 +: 8] == 8'h42, "R10 restart to byte 0", cfg[3*8 +: 8], 8'h42);
    check(cfg[5*8 +: 8] == shadow[5], "R10 byte 5 untouched", cfg[5*8 +: 8], shadow[5]);
    shadow[3] = 8'h42;

    // R7: status byte follows the live input
    sig_det = 8'h0F; wt(4);
    do_read(1);
    check(rbuf[0] == 8'h0F, "R7 live status", rbuf[0], 8'h0F);

    // R11: STOP in the middle of a byte, then a normal write still works
    i2c_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h00, a);
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(H); scl = 1'b0; wt(Q);
    i2c_stop();
    check(sda_oe == 1'b0, "R11 idle after early stop", sda_oe, 0);
    for (int i = 0; i < 4; i++) wbuf[i] = shadow[i];
    wbuf[4] = 8'h66;
    do_write(5);
    check(cfg[4*8 +: 8] == 8'h66, "R11 recovered write", cfg[4*8 +: 8], 8'h66);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule